// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns one interrupt message into a delivery mask over a small set of target interrupt controllers. It has one bit per target. A message arrives in one of two forms. The first is a set of explicit fields: destination, destination mode, shorthand, delivery mode, vector, trigger and level. The second is a message-signalled address/data word pair, which the block decodes into the same fields. Each target presents three values: a physical ID, an 8-bit logical ID and a 4-bit logical model that selects flat or cluster matching.

The block first builds a candidate set. It uses physical matching, logical matching or a shorthand: self, all, or all-but-self relative to the requesting target. The delivery mode then filters that set. Lowest-priority delivery keeps only the lowest-index candidate. Undefined delivery codes reach no one. An INIT de-assert delivers nothing. Instead, each selected target's physical ID is loaded into that target's arbitration ID register. The result is registered and presented with a one-cycle valid strobe, together with the delivery mode, vector and trigger bit.

Top module: `irq_dest_resolver`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, `out_mask` is all zeros and every arbitration ID is 0.
- R2: A request sampled with `req_valid` high at a clock edge produces `out_valid` high for exactly the following cycle. In that cycle `out_dlv_mode`, `out_vector` and `out_trigger` equal the request's values.
- R3: In physical mode (`req_dest_logical`=0, shorthand 0), destination 8'hFF selects every target. Any other destination selects each target whose physical ID equals it.
- R4: In logical mode, a target whose model is 4'hF is selected when the bitwise AND of the destination and its logical ID is non-zero.
- R5: In logical mode, a target whose model is 4'h0 is selected only when destination[7:4] equals logical ID[7:4] and destination[3:0] shares at least one set bit with logical ID[3:0]. A target with any other model is never selected logically.
- R6: The 2-bit shorthand works as follows: 0 uses the destination fields, 1 selects only target `req_src`, 2 selects all targets, and 3 selects all targets except `req_src`.
- R7: For delivery mode 1 (lowest priority), `out_mask` contains only the lowest-index selected target, or is zero if no target is selected.
- R8: The delivery mode codes are 0 fixed, 2 SMI, 4 NMI, 5 INIT, 6 startup and 7 external. Each of these delivers to the full selected set. Code 3 delivers to no target.
- R9: An INIT request (mode 5) with `req_level`=0 and `req_trigger`=1 yields an all-zero `out_mask`. On the same edge it copies each selected target's physical ID into that target's arbitration ID. All other arbitration IDs are unchanged, and no other request alters any arbitration ID.
- R10: With `req_is_msi`=1, the fields are decoded from the message words. The destination is `msi_addr[19:12]` and the destination mode is `msi_addr[2]`. The vector is `msi_data[7:0]`, the delivery mode is `msi_data[10:8]` and the trigger is `msi_data[15]`. The shorthand is 0 and the level counts as asserted.
- R11: In any cycle where `out_valid` is 0, `out_mask` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_msi | input | 1 | Take fields from the message words instead of the explicit fields |
| req_dest | input | 8 | Destination field |
| req_dest_logical | input | 1 | Destination mode: 0 physical, 1 logical |
| req_shorthand | input | 2 | Destination shorthand |
| req_dlv_mode | input | 3 | Delivery mode code |
| req_vector | input | 8 | Interrupt vector |
| req_trigger | input | 1 | Trigger mode: 1 level |
| req_level | input | 1 | Level (assert) bit |
| req_src | input | 3 | Index of the requesting target |
| msi_addr | input | 20 | Message address word (low bits) |
| msi_data | input | 16 | Message data word (low bits) |
| tgt_phys_id | input | 64 | Physical IDs, target i at bits [8i+7:8i] |
| tgt_log_id | input | 64 | Logical IDs, target i at bits [8i+7:8i] |
| tgt_model | input | 32 | Logical models, target i at bits [4i+3:4i] |
| out_valid | output | 1 | One-cycle result strobe |
| out_mask | output | 8 | Delivery mask, bit i = target i |
| out_dlv_mode | output | 3 | Delivery mode of the result |
| out_vector | output | 8 | Vector of the result |
| out_trigger | output | 1 | Trigger mode of the result |
| arb_ids | output | 64 | Arbitration IDs, target i at bits [8i+7:8i] |

## Verification
A wrong matching term or shorthand decode shows up as a wrong bit in `out_mask` in the cycle after the request. The destination sweeps expose it against a fixed target population that mixes flat, cluster and unmatched models. Damage to the lowest-priority pick or to the mode gating appears in that same cycle, as extra bits or missing bits. A corrupted arbitration ID update is invisible on `out_mask`. It is checked on `arb_ids` straight after each INIT de-assert and after ordinary requests that must leave those IDs untouched.

// File: rtl/irq_dest_pkg.sv
// Shared types for the interrupt destination resolver.
// Assumes message field widths fixed by the interrupt message format.
package irq_dest_pkg;
    localparam int ID_W    = 8;
    localparam int MODEL_W = 4;

    localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
    localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;
    localparam logic [ID_W-1:0]    DEST_BCAST    = 8'hFF;

    typedef enum logic [2:0] {
        DLV_FIXED  = 3'd0,
        DLV_LOWEST = 3'd1,
        DLV_SMI    = 3'd2,
        DLV_RSVD3  = 3'd3,
        DLV_NMI    = 3'd4,
        DLV_INIT   = 3'd5,
        DLV_START  = 3'd6,
        DLV_EXT    = 3'd7
    } dlv_mode_e;

    typedef struct packed {
        logic [ID_W-1:0] dest;
        logic            logical;
        logic [1:0]      shorthand;
        dlv_mode_e       mode;
        logic [7:0]      vector;
        logic            trigger;
        logic            level;
    } irq_req_t;
endpackage

// File: rtl/msi_field_decoder.sv
// Decodes a message-signalled address/data pair into request fields.
// Assumes: shorthand is always 0 and the level bit is treated as asserted.
module msi_field_decoder
    import irq_dest_pkg::*;
(
    input  logic [19:0] msi_addr,
    input  logic [15:0] msi_data,
    output irq_req_t    req
);
    // Field extraction from fixed bit positions.
    always_comb begin
        req           = '0;
        req.dest      = msi_addr[19:12];
        req.logical   = msi_addr[2];
        req.shorthand = 2'd0;
        req.vector    = msi_data[7:0];
        req.mode      = dlv_mode_e'(msi_data[10:8]);
        req.trigger   = msi_data[15];
        req.level     = 1'b1;
    end
endmodule

// File: rtl/target_matcher.sv
// Per-target destination match for physical, flat-logical and cluster-logical modes.
// Assumes IDs and models are packed target 0 in the least significant slice.
module target_matcher
    import irq_dest_pkg::*;
#(
    parameter int NUM_TGT = 8
) (
    input  logic [ID_W-1:0]            dest,
    input  logic                       logical,
    input  logic [NUM_TGT*ID_W-1:0]    phys_ids,
    input  logic [NUM_TGT*ID_W-1:0]    log_ids,
    input  logic [NUM_TGT*MODEL_W-1:0] models,
    output logic [NUM_TGT-1:0]         match
);
    localparam int NIB = ID_W / 2;

    for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
        logic [ID_W-1:0]    pid, lid;
        logic [MODEL_W-1:0] mdl;
        logic               phys_hit, flat_hit, clus_hit;
        assign pid = phys_ids[i*ID_W +: ID_W];
        assign lid = log_ids[i*ID_W +: ID_W];
        assign mdl = models[i*MODEL_W +: MODEL_W];

        // Match terms for each addressing style of this target.
        always_comb begin
            phys_hit = (dest == DEST_BCAST) || (dest == pid);
            flat_hit = (mdl == MODEL_FLAT) && ((dest & lid) != '0);
            clus_hit = (mdl == MODEL_CLUSTER)
                       && (dest[ID_W-1:NIB] == lid[ID_W-1:NIB])
                       && ((dest[NIB-1:0] & lid[NIB-1:0]) != '0);
            match[i] = logical ? (flat_hit || clus_hit) : phys_hit;
        end
    end
endmodule

// File: rtl/delivery_filter.sv
// Applies delivery-mode gating to a selected target set.
// Assumes the INIT de-assert flag is already decoded by the caller.
module delivery_filter
    import irq_dest_pkg::*;
#(
    parameter int NUM_TGT = 8
) (
    input  logic [NUM_TGT-1:0] sel,
    input  dlv_mode_e          mode,
    input  logic               init_deassert,
    output logic [NUM_TGT-1:0] dlv
);
    logic [NUM_TGT-1:0] lowest;

    // Isolate the lowest set bit of the selection.
    always_comb lowest = sel & (~sel + 1'b1);

    // Mode-dependent delivery set.
    always_comb begin
        if (init_deassert) begin
            dlv = '0;
        end else begin
            unique case (mode)
                DLV_LOWEST: dlv = lowest;
                DLV_RSVD3:  dlv = '0;
                default:    dlv = sel;
            endcase
        end
    end
endmodule

// File: rtl/irq_dest_resolver.sv
// Top: resolves an interrupt message into a registered per-target delivery mask.
// Assumes at most one request per cycle; result appears one cycle later.
module irq_dest_resolver
    import irq_dest_pkg::*;
#(
    parameter int NUM_TGT = 8,
    parameter int SRC_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_is_msi,
    input  logic [7:0]                 req_dest,
    input  logic                       req_dest_logical,
    input  logic [1:0]                 req_shorthand,
    input  logic [2:0]                 req_dlv_mode,
    input  logic [7:0]                 req_vector,
    input  logic                       req_trigger,
    input  logic                       req_level,
    input  logic [SRC_W-1:0]           req_src,
    input  logic [19:0]                msi_addr,
    input  logic [15:0]                msi_data,
    input  logic [NUM_TGT*8-1:0]       tgt_phys_id,
    input  logic [NUM_TGT*8-1:0]       tgt_log_id,
    input  logic [NUM_TGT*4-1:0]       tgt_model,
    output logic                       out_valid,
    output logic [NUM_TGT-1:0]         out_mask,
    output logic [2:0]                 out_dlv_mode,
    output logic [7:0]                 out_vector,
    output logic                       out_trigger,
    output logic [NUM_TGT*8-1:0]       arb_ids
);
    irq_req_t           msi_req, dir_req, req;
    logic [NUM_TGT-1:0] match, self_mask, sel, dlv;
    logic               init_deassert;

    msi_field_decoder u_msi (
        .msi_addr (msi_addr),
        .msi_data (msi_data),
        .req      (msi_req)
    );

    // Pack the explicit request fields.
    always_comb begin
        dir_req           = '0;
        dir_req.dest      = req_dest;
        dir_req.logical   = req_dest_logical;
        dir_req.shorthand = req_shorthand;
        dir_req.mode      = dlv_mode_e'(req_dlv_mode);
        dir_req.vector    = req_vector;
        dir_req.trigger   = req_trigger;
        dir_req.level     = req_level;
    end

    // Choose the request source.
    always_comb req = req_is_msi ? msi_req : dir_req;

    target_matcher #(.NUM_TGT(NUM_TGT)) u_match (
        .dest     (req.dest),
        .logical  (req.logical),
        .phys_ids (tgt_phys_id),
        .log_ids  (tgt_log_id),
        .models   (tgt_model),
        .match    (match)
    );

    // Shorthand selection of the candidate set.
    always_comb begin
        self_mask = '0;
        self_mask[req_src] = 1'b1;
        unique case (req.shorthand)
            2'd0:    sel = match;
            2'd1:    sel = self_mask;
            2'd2:    sel = '1;
            default: sel = ~self_mask;
        endcase
    end

    // INIT de-assert detection.
    always_comb init_deassert = (req.mode == DLV_INIT) && !req.level && req.trigger;

    delivery_filter #(.NUM_TGT(NUM_TGT)) u_filter (
        .sel           (sel),
        .mode          (req.mode),
        .init_deassert (init_deassert),
        .dlv           (dlv)
    );

    // Output register with one-cycle strobe; fields cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_mask     <= '0;
            out_dlv_mode <= '0;
            out_vector   <= '0;
            out_trigger  <= 1'b0;
        end else begin
            out_valid    <= req_valid;
            out_mask     <= req_valid ? dlv : '0;
            out_dlv_mode <= req_valid ? req.mode : 3'd0;
            out_vector   <= req_valid ? req.vector : 8'd0;
            out_trigger  <= req_valid && req.trigger;
        end
    end

    // Arbitration ID registers, one per target.
    for (genvar i = 0; i < NUM_TGT; i++) begin : g_arb
        // Load the physical ID on an INIT de-assert that selects this target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                arb_ids[i*8 +: 8] <= '0;
            else if (req_valid && init_deassert && sel[i])
                arb_ids[i*8 +: 8] <= tgt_phys_id[i*8 +: 8];
        end
    end
endmodule

// File: rtl/irq_dest_resolver_chk.sv
// Checker for irq_dest_resolver: strobe timing, mask shape and arbitration ID stability.
// Assumes it is bound to the top with default parameters or matching ones.
module irq_dest_resolver_chk #(
    parameter int NUM_TGT = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 out_valid,
    input logic [NUM_TGT-1:0]   out_mask,
    input logic [2:0]           out_dlv_mode,
    input logic [NUM_TGT*8-1:0] arb_ids
);
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    a_r7_lowest_single: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dlv_mode == 3'd1) |-> $onehot0(out_mask));
    a_r8_code3_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dlv_mode == 3'd3) |-> (out_mask == '0));
    a_r9_arb_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(arb_ids));
    a_r11_idle_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_mask == '0));
endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(.NUM_TGT(NUM_TGT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .out_valid    (out_valid),
    .out_mask     (out_mask),
    .out_dlv_mode (out_dlv_mode),
    .arb_ids      (arb_ids)
);

// File: tb/irq_dest_resolver_tb.sv
`timescale 1ns/100ps
module irq_dest_resolver_tb;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_is_msi, req_dest_logical, req_trigger, req_level;
    logic [7:0]   req_dest, req_vector;
    logic [1:0]   req_shorthand;
    logic [2:0]   req_dlv_mode, req_src;
    logic [19:0]  msi_addr;
    logic [15:0]  msi_data;
    logic [N*8-1:0] tgt_phys_id, tgt_log_id, arb_ids;
    logic [N*4-1:0] tgt_model;
    logic         out_valid, out_trigger;
    logic [N-1:0] out_mask;
    logic [2:0]   out_dlv_mode;
    logic [7:0]   out_vector;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_dest_resolver #(.NUM_TGT(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_msi(req_is_msi),
        .req_dest(req_dest), .req_dest_logical(req_dest_logical),
        .req_shorthand(req_shorthand), .req_dlv_mode(req_dlv_mode),
        .req_vector(req_vector), .req_trigger(req_trigger), .req_level(req_level),
        .req_src(req_src), .msi_addr(msi_addr), .msi_data(msi_data),
        .tgt_phys_id(tgt_phys_id), .tgt_log_id(tgt_log_id), .tgt_model(tgt_model),
        .out_valid(out_valid), .out_mask(out_mask), .out_dlv_mode(out_dlv_mode),
        .out_vector(out_vector), .out_trigger(out_trigger), .arb_ids(arb_ids)
    );

    // Target population: physical IDs 3i+1; 0..3 flat with one logical bit each,
    // 4..6 cluster 2 with one member bit each, 7 an unmatched model.
    function automatic logic [7:0] pid(int i); return 8'(3 * i + 1); endfunction
    function automatic logic [7:0] lid(int i);
        if (i < 4) return 8'(1 << i);
        if (i < 7) return 8'h20 | 8'(1 << (i - 4));
        return 8'hFF;
    endfunction
    function automatic logic [3:0] mdl(int i);
        if (i < 4) return 4'hF;
        if (i < 7) return 4'h0;
        return 4'h5;
    endfunction

    function automatic logic [N-1:0] exp_sel(logic [7:0] d, logic lg, logic [1:0] sh, int src);
        logic [N-1:0] m = '0;
        case (sh)
            2'd1: m[src] = 1'b1;
            2'd2: m = '1;
            2'd3: begin m = '1; m[src] = 1'b0; end
            default:
                for (int i = 0; i < N; i++) begin
                    if (!lg) m[i] = (d == 8'hFF) || (d == pid(i));
                    else if (mdl(i) == 4'hF) m[i] = (d & lid(i)) != 0;
                    else if (mdl(i) == 4'h0)
                        m[i] = (d[7:4] == lid(i)[7:4]) && ((d[3:0] & lid(i)[3:0]) != 0);
                end
        endcase
        return m;
    endfunction

    function automatic logic [N-1:0] exp_dlv(logic [N-1:0] s, logic [2:0] md, logic deassert);
        if (deassert || md == 3'd3) return '0;
        if (md == 3'd1) begin
            for (int i = 0; i < N; i++) if (s[i]) return N'(1 << i);
            return '0;
        end
        return s;
    endfunction

    task automatic chk(string r, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // Drive one explicit request, then check outputs one cycle later.
    task automatic send(string r, logic [7:0] d, logic lg, logic [1:0] sh, logic [2:0] md,
                        logic [7:0] vec, logic trg, logic lvl, int src);
        logic [N-1:0] e;
        @(negedge clk);
        req_valid = 1; req_is_msi = 0; req_dest = d; req_dest_logical = lg;
        req_shorthand = sh; req_dlv_mode = md; req_vector = vec; req_trigger = trg;
        req_level = lvl; req_src = 3'(src);
        e = exp_dlv(exp_sel(d, lg, sh, src), md, md == 3'd5 && !lvl && trg);
        @(negedge clk);
        req_valid = 0;
        chk(r, {out_valid, out_mask, out_dlv_mode, out_vector, out_trigger},
               {1'b1, e, md, vec, trg});
    endtask

    task automatic send_msi(string r, logic [7:0] d, logic lg, logic [2:0] md,
                            logic [7:0] vec, logic trg);
        logic [N-1:0] e;
        @(negedge clk);
        req_valid = 1; req_is_msi = 1;
        req_shorthand = 2'd1; req_level = 0; req_src = 3'd7; // ignored fields
        msi_addr = {d, 9'h0, lg, 2'b00};
        msi_data = {trg, 4'h0, md, vec};
        e = exp_dlv(exp_sel(d, lg, 2'd0, 0), md, 1'b0);
        @(negedge clk);
        req_valid = 0;
        chk(r, {out_valid, out_mask, out_dlv_mode, out_vector, out_trigger},
               {1'b1, e, md, vec, trg});
    endtask

    logic [N*8-1:0] arb_exp;

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            tgt_phys_id[i*8 +: 8] = pid(i);
            tgt_log_id[i*8 +: 8]  = lid(i);
            tgt_model[i*4 +: 4]   = mdl(i);
        end
        req_valid = 0; req_is_msi = 0; req_dest = 0; req_dest_logical = 0;
        req_shorthand = 0; req_dlv_mode = 0; req_vector = 0; req_trigger = 0;
        req_level = 1; req_src = 0; msi_addr = 0; msi_data = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {out_valid, out_mask, arb_ids}, '0);
        rst_n = 1;
        @(negedge clk);
        chk("R11", {out_valid, out_mask}, '0);

        // R3 physical sweep, fixed delivery (also R2 fields)
        for (int d = 0; d < 256; d++)
            send("R3", 8'(d), 1'b0, 2'd0, 3'd0, 8'(d ^ 8'h5A), d[0], 1'b1, 0);
        // R4/R5 logical sweep
        for (int d = 0; d < 256; d++)
            send("R4_R5", 8'(d), 1'b1, 2'd0, 3'd0, 8'(d), 1'b0, 1'b1, 0);
        // R6 shorthands for every source
        for (int s = 0; s < N; s++)
            for (int sh = 1; sh < 4; sh++)
                send("R6", 8'h00, 1'b0, 2'(sh), 3'd4, 8'h33, 1'b0, 1'b1, s);
        // R7 lowest priority over logical and shorthand sets
        for (int d = 0; d < 256; d += 3)
            send("R7", 8'(d), 1'b1, 2'd0, 3'd1, 8'h41, 1'b1, 1'b1, 0);
        for (int s = 0; s < N; s++)
            send("R7", 8'h00, 1'b0, 2'd3, 3'd1, 8'h42, 1'b0, 1'b1, s);
        // R8 every delivery code to broadcast
        for (int m = 0; m < 8; m++)
            send("R8", 8'hFF, 1'b0, 2'd0, 3'(m), 8'h90, 1'b0, 1'b1, 0);
        // R9 ordinary INIT (level set) and other traffic leave arbitration IDs at 0
        send("R9", 8'hFF, 1'b0, 2'd0, 3'd5, 8'h00, 1'b1, 1'b1, 0);
        @(negedge clk);
        chk("R9", arb_ids, '0);
        // R9 de-assert to target 2 only
        send("R9", pid(2), 1'b0, 2'd0, 3'd5, 8'h00, 1'b1, 1'b0, 0);
        arb_exp = '0; arb_exp[2*8 +: 8] = pid(2);
        chk("R9", arb_ids, arb_exp);
        // R9 de-assert to all but target 5
        send("R9", 8'h00, 1'b0, 2'd3, 3'd5, 8'h00, 1'b1, 1'b0, 5);
        for (int i = 0; i < N; i++) if (i != 5) arb_exp[i*8 +: 8] = pid(i);
        chk("R9", arb_ids, arb_exp);
        send("R9", 8'hFF, 1'b0, 2'd0, 3'd0, 8'h10, 1'b0, 1'b0, 0);
        chk("R9", arb_ids, arb_exp);
        // R10 message decode
        for (int d = 0; d < 256; d += 5)
            for (int m = 0; m < 8; m++)
                send_msi("R10", 8'(d), d[1], 3'(m), 8'(d + m), m[0]);
        send_msi("R10", 8'h00, 1'b0, 3'd5, 8'h00, 1'b1);
        chk("R10", arb_ids, arb_exp);
        // R2/R11 back to idle
        @(negedge clk);
        chk("R2_R11", {out_valid, out_mask, out_dlv_mode, out_vector, out_trigger}, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule